// File: doc/BRIEF.md
# Reset Supervisor with Hold-Time Button Decoding

This block produces the active-low system reset for a processor. It also serves the single reset push-button on the board. When the power-good input rises, the block keeps reset asserted for a long cold interval, which gives a slow low-frequency oscillator time to start. The power-good input is low during a brownout. Any low level on it forces reset at once and restarts the whole cold interval.

While the system runs, the button is debounced and the block counts how long it is held. Only the release acts, and the action depends on the hold time:
- A short hold issues a brief warm reset pulse.
- A medium hold flips the external watchdog-enable output and issues no reset.
- A long hold latches the boot-mode-select output high and then issues a warm reset, so the processor starts in its boot monitor. That latch clears only at the next power-up.

A status LED shows the watchdog-enable level when the button is idle. It blinks slowly while a held press is in the medium range and quickly once the long threshold has been passed. Every time constant is a cycle-count parameter. The defaults derive from `CLK_HZ` (0.9 s cold, 92 µs warm, 2 s and 10 s thresholds, 20 ms debounce). A simulation passes short counts to the same parameters.

Top module: `rst_supervisor`

## Requirements
- R1: After `powerGood` rises, `rstN` stays low for exactly `COLD_CYC` clock cycles. At that release `bootSel`, `wdogEn` and `led` are all 0.
- R2: A low level on `powerGood` drives `rstN` low with no clock edge needed and clears `wdogEn`. When `powerGood` returns high, the full `COLD_CYC` interval runs again.
- R3: A level on `btnRaw` (1 = pressed) that lasts fewer than `DEB_CYC - 1` cycles is ignored. It causes no reset pulse and no change of `wdogEn`.
- R4: A press held for fewer than `SHORT_CYC` cycles produces, after its release, one `rstN` low pulse of exactly `WARM_CYC` cycles. `wdogEn` is left unchanged.
- R5: A press held for at least `SHORT_CYC` and fewer than `LONG_CYC` cycles inverts `wdogEn` on release and produces no reset pulse.
- R6: A press held for `LONG_CYC` cycles or more sets `bootSel` to 1 on release and produces one `rstN` low pulse of `WARM_CYC` cycles.
- R7: Once set, `bootSel` stays 1 through later warm resets and presses. Only a low level on `powerGood` clears it.
- R8: With the button idle, `led` equals `wdogEn`. During a held press in the medium range, `led` toggles every `SLOW_HALF` cycles. Past `LONG_CYC`, it toggles every `FAST_HALF` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| powerGood | input | 1 | Supply good, low during brownout; asynchronous reset source |
| btnRaw | input | 1 | Undebounced push-button level, 1 = pressed |
| rstN | output | 1 | Active-low system reset |
| bootSel | output | 1 | Boot-mode select, 1 = boot monitor |
| wdogEn | output | 1 | External watchdog enable |
| led | output | 1 | Status LED drive |

## Verification
An internal fault shows at the ports within one reset interval or one press:
- A pulse counter that is off or stuck changes the measured low width of `rstN`. It shows at the first cold or warm pulse, or as a reset that never ends.
- A hold counter or range comparison that is wrong picks the wrong action. It shows on the cycle after the debounced release, either as a missing or extra reset pulse, or as a wrong `wdogEn` or `bootSel`.
- Debounce faults show as a glitch that triggers a reset.
- Blink-rate faults show as the wrong number of `led` toggles in a fixed window during a held press.

The exact threshold holds `SHORT_CYC - 1`, `SHORT_CYC`, `LONG_CYC - 1` and `LONG_CYC` pin each comparison to a single cycle.

// File: rtl/rst_supervisor_pkg.sv
package rst_supervisor_pkg;

  typedef enum logic [1:0] {
    ST_COLD = 2'd0,
    ST_RUN  = 2'd1,
    ST_WARM = 2'd2
  } supState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic pulseEn;   // run the reset-width counter (else it clears)
    logic holdEn;    // allow hold-time counting while pressed
    logic holdClr;   // clear the hold-time counter
  } ctlStrb_t;

endpackage

// File: rtl/rst_supervisor_dp.sv
module rst_supervisor_dp
  import rst_supervisor_pkg::*;
#(
  parameter int COLD_CYC  = 900000,
  parameter int WARM_CYC  = 92,
  parameter int LONG_CYC  = 10000000,
  parameter int DEB_CYC   = 20000,
  parameter int SLOW_HALF = 250000,
  parameter int FAST_HALF = 62500
) (
  input  logic                          clk,
  input  logic                          rstI,
  input  logic                          btnRaw,
  input  ctlStrb_t                      strb,
  output logic                          debBtn,
  output logic [$clog2(LONG_CYC+1)-1:0] holdCnt,
  output logic                          coldDone,
  output logic                          warmDone,
  output logic [1:0]                    blink
);

  localparam int HOLD_W  = $clog2(LONG_CYC + 1);
  localparam int PULSE_W = $clog2(COLD_CYC + 1);
  localparam int DEB_W   = $clog2(DEB_CYC + 1);
  localparam int BLINK_W = $clog2(SLOW_HALF + 1);
  // two cycles of power-good synchronisation precede the cold count
  localparam logic [PULSE_W-1:0] COLD_LAST = PULSE_W'(COLD_CYC - 3);
  localparam logic [PULSE_W-1:0] WARM_LAST = PULSE_W'(WARM_CYC - 1);
  localparam logic [DEB_W-1:0]   DEB_LAST  = DEB_W'(DEB_CYC - 1);
  localparam logic [HOLD_W-1:0]  LONG_V    = HOLD_W'(LONG_CYC);

  logic [1:0]         btnSync;
  logic [DEB_W-1:0]   debCnt;
  logic [PULSE_W-1:0] pulseCnt;

  // button synchroniser and stability filter
  always_ff @(posedge clk or posedge rstI) begin
    if (rstI) begin
      btnSync <= '0;
      debCnt  <= '0;
      debBtn  <= 1'b0;
    end else begin
      btnSync <= {btnSync[0], btnRaw};
      if (btnSync[1] == debBtn) begin
        debCnt <= '0;
      end else if (debCnt == DEB_LAST) begin
        debBtn <= btnSync[1];
        debCnt <= '0;
      end else begin
        debCnt <= debCnt + 1'b1;
      end
    end
  end

  // press duration, saturating at the long threshold
  always_ff @(posedge clk or posedge rstI) begin
    if (rstI) begin
      holdCnt <= '0;
    end else if (strb.holdClr) begin
      holdCnt <= '0;
    end else if (strb.holdEn && debBtn && holdCnt != LONG_V) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  // shared reset-width counter for cold and warm pulses
  always_ff @(posedge clk or posedge rstI) begin
    if (rstI)              pulseCnt <= '0;
    else if (strb.pulseEn) pulseCnt <= pulseCnt + 1'b1;
    else                   pulseCnt <= '0;
  end

  assign coldDone = (pulseCnt == COLD_LAST);
  assign warmDone = (pulseCnt == WARM_LAST);

  // blink phase generators: index 0 slow, index 1 fast
  for (genvar g = 0; g < 2; g++) begin : gBlink
    localparam int HALF = (g == 0) ? SLOW_HALF : FAST_HALF;
    localparam logic [BLINK_W-1:0] HALF_LAST = BLINK_W'(HALF - 1);
    logic [BLINK_W-1:0] cnt;
    always_ff @(posedge clk or posedge rstI) begin
      if (rstI) begin
        cnt      <= '0;
        blink[g] <= 1'b0;
      end else if (cnt == HALF_LAST) begin
        cnt      <= '0;
        blink[g] <= ~blink[g];
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rstI)
    holdCnt <= LONG_V);

  // R3
  deb_settle_chk: assert property (@(posedge clk) disable iff (rstI)
    (debBtn != $past(debBtn)) |-> ($past(debCnt) == DEB_LAST));

endmodule

// File: rtl/rst_supervisor_ctl.sv
module rst_supervisor_ctl
  import rst_supervisor_pkg::*;
#(
  parameter int SHORT_CYC = 2000000,
  parameter int LONG_CYC  = 10000000
) (
  input  logic                          clk,
  input  logic                          rstI,
  input  logic                          debBtn,
  input  logic [$clog2(LONG_CYC+1)-1:0] holdCnt,
  input  logic                          coldDone,
  input  logic                          warmDone,
  input  logic [1:0]                    blink,
  output ctlStrb_t                      strb,
  output logic                          rstN,
  output logic                          bootSel,
  output logic                          wdogEn,
  output logic                          led
);

  localparam int HOLD_W = $clog2(LONG_CYC + 1);
  localparam logic [HOLD_W-1:0] SHORT_V = HOLD_W'(SHORT_CYC);
  localparam logic [HOLD_W-1:0] LONG_V  = HOLD_W'(LONG_CYC);

  supState_t state, nState;
  logic setBoot, togWd, ledNext;

  always_comb begin
    nState  = state;
    strb    = '0;
    setBoot = 1'b0;
    togWd   = 1'b0;
    unique case (state)
      ST_COLD: begin
        strb.pulseEn = 1'b1;
        strb.holdClr = 1'b1;
        if (coldDone) nState = ST_RUN;
      end
      ST_RUN: begin
        strb.holdEn = 1'b1;
        if (!debBtn && holdCnt != '0) begin
          strb.holdClr = 1'b1;
          if (holdCnt < SHORT_V) begin
            nState = ST_WARM;
          end else if (holdCnt < LONG_V) begin
            togWd = 1'b1;
          end else begin
            setBoot = 1'b1;
            nState  = ST_WARM;
          end
        end
      end
      ST_WARM: begin
        strb.pulseEn = 1'b1;
        strb.holdClr = 1'b1;
        if (warmDone) nState = ST_RUN;
      end
      default: nState = ST_COLD;
    endcase
  end

  always_comb begin
    if (state == ST_RUN && debBtn && holdCnt >= LONG_V)       ledNext = blink[1];
    else if (state == ST_RUN && debBtn && holdCnt >= SHORT_V) ledNext = blink[0];
    else                                                      ledNext = wdogEn ^ togWd;
  end

  always_ff @(posedge clk or posedge rstI) begin
    if (rstI) begin
      state   <= ST_COLD;
      rstN    <= 1'b0;
      bootSel <= 1'b0;
      wdogEn  <= 1'b0;
      led     <= 1'b0;
    end else begin
      state   <= nState;
      rstN    <= (nState == ST_RUN);
      bootSel <= bootSel | setBoot;
      wdogEn  <= wdogEn ^ togWd;
      led     <= ledNext;
    end
  end

  // R1 R4
  rst_rise_chk: assert property (@(posedge clk) disable iff (rstI)
    $rose(rstN) |-> $past(coldDone || warmDone));

  // R7
  boot_hold_chk: assert property (@(posedge clk) disable iff (rstI)
    bootSel |=> bootSel);

  // R6
  boot_with_rst_chk: assert property (@(posedge clk) disable iff (rstI)
    $rose(bootSel) |-> $fell(rstN));

  // R5
  wdog_change_chk: assert property (@(posedge clk) disable iff (rstI)
    (wdogEn != $past(wdogEn)) |->
      ($past(state) == ST_RUN && !$past(debBtn) && $past(holdCnt) >= SHORT_V));

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import rst_supervisor_pkg::*;
#(
  parameter int CLK_HZ    = 1000000,
  parameter int COLD_CYC  = (CLK_HZ / 10) * 9,
  parameter int WARM_CYC  = ((CLK_HZ / 1000) * 92) / 1000,
  parameter int SHORT_CYC = 2 * CLK_HZ,
  parameter int LONG_CYC  = 10 * CLK_HZ,
  parameter int DEB_CYC   = CLK_HZ / 50,
  parameter int SLOW_HALF = CLK_HZ / 4,
  parameter int FAST_HALF = CLK_HZ / 16
) (
  input  logic clk,
  input  logic powerGood,
  input  logic btnRaw,
  output logic rstN,
  output logic bootSel,
  output logic wdogEn,
  output logic led
);

  localparam int HOLD_W = $clog2(LONG_CYC + 1);

  logic [1:0]        pgSync;
  logic              rstI;
  ctlStrb_t          strb;
  logic              debBtn, coldDone, warmDone;
  logic [HOLD_W-1:0] holdCnt;
  logic [1:0]        blink;

  // asynchronous assertion, synchronised release
  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood) pgSync <= '0;
    else            pgSync <= {pgSync[0], 1'b1};
  end
  assign rstI = ~pgSync[1];

  rst_supervisor_dp #(
    .COLD_CYC (COLD_CYC),
    .WARM_CYC (WARM_CYC),
    .LONG_CYC (LONG_CYC),
    .DEB_CYC  (DEB_CYC),
    .SLOW_HALF(SLOW_HALF),
    .FAST_HALF(FAST_HALF)
  ) i_dp (
    .clk     (clk),
    .rstI    (rstI),
    .btnRaw  (btnRaw),
    .strb    (strb),
    .debBtn  (debBtn),
    .holdCnt (holdCnt),
    .coldDone(coldDone),
    .warmDone(warmDone),
    .blink   (blink)
  );

  rst_supervisor_ctl #(
    .SHORT_CYC(SHORT_CYC),
    .LONG_CYC (LONG_CYC)
  ) i_ctl (
    .clk     (clk),
    .rstI    (rstI),
    .debBtn  (debBtn),
    .holdCnt (holdCnt),
    .coldDone(coldDone),
    .warmDone(warmDone),
    .blink   (blink),
    .strb    (strb),
    .rstN    (rstN),
    .bootSel (bootSel),
    .wdogEn  (wdogEn),
    .led     (led)
  );

endmodule

// File: tb/test_rst_supervisor.sv
`timescale 1ns/1ps
module test_rst_supervisor;

  localparam int COLD  = 40;
  localparam int WARM  = 12;
  localparam int SHORT = 200;
  localparam int LONG  = 600;
  localparam int DEB   = 8;
  localparam int SLOW  = 16;
  localparam int FAST  = 4;
  localparam int SETTLE = DEB + WARM + 20;

  logic clk = 1'b0;
  logic powerGood = 1'b0;
  logic btnRaw = 1'b0;
  logic rstN, bootSel, wdogEn, led;

  always #2 clk = ~clk;

  rst_supervisor #(
    .COLD_CYC(COLD), .WARM_CYC(WARM), .SHORT_CYC(SHORT), .LONG_CYC(LONG),
    .DEB_CYC(DEB), .SLOW_HALF(SLOW), .FAST_HALF(FAST)
  ) i_rst_supervisor (
    .clk(clk), .powerGood(powerGood), .btnRaw(btnRaw),
    .rstN(rstN), .bootSel(bootSel), .wdogEn(wdogEn), .led(led)
  );

  typedef struct { int width; string tag; } pulseExp_t;
  pulseExp_t expQ[$];

  int  nChk = 0;
  int  nFail = 0;
  bit  armed = 1'b0;
  bit  done = 1'b0;

  task automatic check(string tag, string what, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic checkRange(string tag, string what, int act, int lo, int hi);
    nChk++;
    if (act < lo || act > hi) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", tag, what, act, lo, hi);
    end
  endtask

  task automatic expectPulse(int w, string tag);
    pulseExp_t e;
    e.width = w;
    e.tag   = tag;
    expQ.push_back(e);
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(int p);
    @(negedge clk);
    btnRaw = 1'b1;
    repeat (p) @(negedge clk);
    btnRaw = 1'b0;
    waitCycles(SETTLE);
  endtask

  task automatic countToggles(int win, output int t);
    logic prev;
    t = 0;
    prev = led;
    repeat (win) begin
      @(negedge clk);
      if (led !== prev) t++;
      prev = led;
    end
  endtask

  // monitor: measures each rstN low pulse and compares with the queue
  initial begin
    int w;
    w = 0;
    forever begin
      @(negedge clk);
      #1;
      if (armed) begin
        if (rstN === 1'b0) begin
          w++;
        end else if (w > 0) begin
          if (expQ.size() == 0) begin
            nChk++;
            nFail++;
            $display("FAIL R3 unexpected reset pulse: actual %0d expected 0", w);
          end else begin
            pulseExp_t e;
            e = expQ.pop_front();
            check(e.tag, "reset pulse width", w, e.width);
          end
          w = 0;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int t;
    repeat (5) @(negedge clk);
    // R1: cold power-up
    expectPulse(COLD, "R1");
    powerGood = 1'b1;
    armed = 1'b1;
    waitCycles(COLD + 5);
    check("R1", "rstN after cold", int'(rstN), 1);
    check("R1", "bootSel after cold", int'(bootSel), 0);
    check("R1", "wdogEn after cold", int'(wdogEn), 0);
    check("R1", "led after cold", int'(led), 0);

    // R4: short presses, including one cycle below the threshold
    expectPulse(WARM, "R4");
    press(100);
    check("R4", "wdogEn after short", int'(wdogEn), 0);
    expectPulse(WARM, "R4");
    press(SHORT - 1);
    check("R4", "wdogEn after SHORT-1", int'(wdogEn), 0);

    // R5: medium presses at both edges of the range
    press(SHORT);
    check("R5", "wdogEn after SHORT", int'(wdogEn), 1);
    check("R8", "idle led shows wdogEn", int'(led), 1);
    press(LONG - 1);
    check("R5", "wdogEn after LONG-1", int'(wdogEn), 0);
    check("R8", "idle led shows wdogEn", int'(led), 0);

    // R3: glitch shorter than the filter
    @(negedge clk);
    btnRaw = 1'b1;
    repeat (DEB - 2) @(negedge clk);
    btnRaw = 1'b0;
    waitCycles(SETTLE);
    check("R3", "rstN after glitch", int'(rstN), 1);
    check("R3", "wdogEn after glitch", int'(wdogEn), 0);

    // R6: long press at the threshold
    expectPulse(WARM, "R6");
    press(LONG);
    check("R6", "bootSel after LONG", int'(bootSel), 1);
    check("R6", "rstN back high", int'(rstN), 1);

    // R7: bootSel survives later warm reset
    expectPulse(WARM, "R7");
    press(50);
    check("R7", "bootSel after later reset", int'(bootSel), 1);

    // R8: blink rates during a held long press
    expectPulse(WARM, "R8");
    @(negedge clk);
    btnRaw = 1'b1;
    waitCycles(300);
    countToggles(64, t);
    checkRange("R8", "slow blink toggles", t, 3, 5);
    waitCycles(336);
    countToggles(64, t);
    checkRange("R8", "fast blink toggles", t, 14, 18);
    waitCycles(100);
    btnRaw = 1'b0;
    waitCycles(SETTLE);
    check("R8", "wdogEn after blink press", int'(wdogEn), 0);

    // set watchdog enable, then brownout
    press(SHORT + 50);
    check("R5", "wdogEn after medium", int'(wdogEn), 1);
    @(negedge clk);
    expectPulse(10 + COLD, "R2");
    powerGood = 1'b0;
    #1;
    check("R2", "rstN immediate on brownout", int'(rstN), 0);
    repeat (10) @(negedge clk);
    powerGood = 1'b1;
    waitCycles(COLD + 5);
    check("R2", "rstN after brownout", int'(rstN), 1);
    check("R2", "wdogEn cleared by brownout", int'(wdogEn), 0);
    check("R7", "bootSel cleared by power-up", int'(bootSel), 0);

    waitCycles(4);
    while (expQ.size() > 0) begin
      pulseExp_t e;
      e = expQ.pop_front();
      nChk++;
      nFail++;
      $display("FAIL %s missing reset pulse: actual 0 expected %0d", e.tag, e.width);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule